// File: doc/BRIEF.md
# Indexed Peripheral Clock Divider Bank

This block holds one clock configuration per peripheral and drives one divided clock-enable stream for each. All entries are reached through a single shared 32-bit control register. Software first writes a peripheral number to pick an entry. A read then shows that entry's stored source, divisor and enable. A write that also carries the command bit changes the entry named in that write.

Each source clock arrives as a one-cycle tick strobe in the block's clock domain. An enabled entry counts the ticks of its chosen source and emits an output tick once every (divider field + 1) source ticks. Each running entry takes its source and divisor only while it is stopped. Writes made to an entry that is running update what reads return, but leave the output stream as it was until the entry is stopped and started again.

Top module: `gck_bank`

## Requirements
- R1: Register layout: peripheral number in bits [6:0], source select in bits [10:8], command in bit 12, divider in bits [27:20], enable in bit 29. Every other bit reads as zero and bit 12 reads as zero. A write with bit 12 clear only latches the peripheral number. Reads then return that entry's stored source, divider and enable, together with the latched number.
- R2: A write with bit 12 set and bit 29 set stores the source, divider and enable into the entry named by bits [6:0] of that same write, and latches that number.
- R3: A write with bit 12 set and bit 29 clear clears only the enable of the named entry. Its stored source and divider stay as they were, and its output stops.
- R4: An enabled entry with divider value D emits one output tick every D+1 ticks of its selected source, so D runs from 0 to 255. With D = 0 the output equals the selected source tick.
- R5: Sources 0 to 5 are selectable. A stored source value of 6 or 7 reads back as written but yields no output tick while the entry is enabled.
- R6: Any write naming peripheral 0, 1, or a number of 64 or more changes neither the latched number nor any entry.
- R7: While an entry is running, its output keeps the source and divider it started with, even if a new enabling write changes the stored values. Those stored values take effect once the entry has been disabled and then enabled again.
- R8: After reset every entry holds source 0, divider 0 and enable clear. The latched number is 0, reads return zero and no output ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the latched peripheral |
| src_tick | input | 6 | One tick strobe per source clock |
| gck_tick | output | 64 | Divided output tick per peripheral |

## Verification
A configuration write can land on an entry whose divider is running, so a register update and a counter reload can fall in the same cycle. The bench provokes this by rewriting the divisor of a running entry. It then judges two things. The read port must show the new value at once. The measured output period must keep the old divisor until a disable and a fresh enable, after which the new period must appear.

// File: rtl/gck_pkg.sv
package gck_pkg;
    parameter int DIV_W   = 8;
    parameter int SRC_W   = 3;
    parameter int ID_W    = 7;
    parameter int REG_W   = 32;
    // field positions in the shared control register
    parameter int ID_LSB  = 0;
    parameter int SRC_LSB = 8;
    parameter int CMD_BIT = 12;
    parameter int DIV_LSB = 20;
    parameter int EN_BIT  = 29;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } cfg_t;
endpackage

// File: rtl/gck_regwin.sv
module gck_regwin
    import gck_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int ID_MIN      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [REG_W-1:0]             wdata_i,
    output logic [REG_W-1:0]             rdata_o,
    output cfg_t [NUM_ENTRIES-1:0]       cfg_o
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int ID_W1 = ID_W + 1;
    localparam logic [ID_W1-1:0] ID_LO = ID_W1'(ID_MIN);
    localparam logic [ID_W1-1:0] ID_HI = ID_W1'(NUM_ENTRIES);

    typedef struct packed {
        logic [ID_W-1:0]         sel;
        cfg_t [NUM_ENTRIES-1:0]  tbl;
    } state_t;

    state_t state_d, state_q;

    logic [ID_W-1:0]  w_id;
    logic [IDX_W-1:0] w_idx;
    logic [SRC_W-1:0] w_src;
    logic [DIV_W-1:0] w_div;
    logic             w_cmd, w_en, id_ok;
    logic [IDX_W-1:0] r_idx;

    assign w_id  = wdata_i[ID_LSB +: ID_W];
    assign w_idx = w_id[IDX_W-1:0];
    assign w_src = wdata_i[SRC_LSB +: SRC_W];
    assign w_div = wdata_i[DIV_LSB +: DIV_W];
    assign w_cmd = wdata_i[CMD_BIT];
    assign w_en  = wdata_i[EN_BIT];
    assign id_ok = ({1'b0, w_id} >= ID_LO) && ({1'b0, w_id} < ID_HI);

    always_comb begin
        state_d = state_q;
        if (wr_i && id_ok) begin
            state_d.sel = w_id;
            if (w_cmd) begin
                if (w_en) begin
                    state_d.tbl[w_idx] = '{en: 1'b1, src: w_src, div: w_div};
                end else begin
                    state_d.tbl[w_idx].en = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign r_idx = state_q.sel[IDX_W-1:0];

    always_comb begin
        rdata_o = '0;
        rdata_o[ID_LSB  +: ID_W]  = state_q.sel;
        rdata_o[SRC_LSB +: SRC_W] = state_q.tbl[r_idx].src;
        rdata_o[DIV_LSB +: DIV_W] = state_q.tbl[r_idx].div;
        rdata_o[EN_BIT]           = state_q.tbl[r_idx].en;
    end

    assign cfg_o = state_q.tbl;

    // R6
    bad_id_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !id_ok) |=> $stable(state_q));

    // R1
    select_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && id_ok && !w_cmd) |=> ($stable(state_q.tbl) && state_q.sel == $past(w_id)));

    // R2
    cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && id_ok && w_cmd && w_en) |=>
        (rdata_o[EN_BIT] && rdata_o[DIV_LSB +: DIV_W] == $past(w_div)
         && rdata_o[SRC_LSB +: SRC_W] == $past(w_src)));

    // R3
    disable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && id_ok && w_cmd && !w_en) |=>
        (!rdata_o[EN_BIT] && state_q.tbl[$past(w_idx)].div == $past(state_q.tbl[w_idx].div)
         && state_q.tbl[$past(w_idx)].src == $past(state_q.tbl[w_idx].src)));

    logic unused_bits;
    assign unused_bits = ^{wdata_i[REG_W-1:EN_BIT+1], wdata_i[EN_BIT-1:DIV_LSB+DIV_W],
                           wdata_i[DIV_LSB-1:CMD_BIT+1], wdata_i[CMD_BIT-1:SRC_LSB+SRC_W],
                           wdata_i[SRC_LSB-1:ID_LSB+ID_W], w_id[ID_W-1:IDX_W]};
endmodule

// File: rtl/gck_div.sv
module gck_div
    import gck_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_t               cfg_i,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               tick_o
);
    localparam int SRC_SPAN = 1 << SRC_W;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } run_t;

    run_t run_d, run_q;
    logic [SRC_SPAN-1:0] src_pad;
    logic                sel_tick;

    assign src_pad  = SRC_SPAN'(src_i);
    assign sel_tick = src_pad[run_q.src];
    assign tick_o   = run_q.en && sel_tick && (run_q.cnt == '0);

    always_comb begin
        run_d = run_q;
        if (!run_q.en) begin
            // stopped: take the stored setting, so a start is clean
            run_d.src = cfg_i.src;
            run_d.div = cfg_i.div;
            run_d.cnt = cfg_i.div;
            run_d.en  = cfg_i.en;
        end else begin
            run_d.en = cfg_i.en;
            if (sel_tick) begin
                run_d.cnt = (run_q.cnt == '0) ? run_q.div : run_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_q.en) && run_q.en) |-> ($stable(run_q.div) && $stable(run_q.src)));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q.en |-> (run_q.cnt <= run_q.div));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && cfg_i.en) |=> (run_q.cnt == run_q.div));

    // R5
    no_src_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(run_q.src) >= NUM_SRC) |-> !tick_o);
endmodule

// File: rtl/gck_bank.sv
module gck_bank
    import gck_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int ID_MIN      = 2,
    parameter int NUM_SRC     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic [NUM_SRC-1:0]     src_tick,
    output logic [NUM_ENTRIES-1:0] gck_tick
);
    cfg_t [NUM_ENTRIES-1:0] cfg;

    gck_regwin #(.NUM_ENTRIES(NUM_ENTRIES), .ID_MIN(ID_MIN)) u_regwin (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .cfg_o   (cfg)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        gck_div #(.NUM_SRC(NUM_SRC)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_i  (cfg[i]),
            .src_i  (src_tick),
            .tick_o (gck_tick[i])
        );
    end

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (gck_tick == '0 && reg_rdata == '0));
endmodule

// File: tb/tb_gck_bank.sv
module tb_gck_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  src_tick = '0;
    logic [63:0] gck_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    gck_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .src_tick(src_tick), .gck_tick(gck_tick)
    );

    always #5 clk = ~clk;

    // source k ticks once every k+2 cycles
    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int k = 0; k < 6; k++) src_tick[k] <= ((cyc % (k + 2)) == 0);
    end

    function automatic logic [31:0] mk(int id, int src, int div, bit cmd, bit en);
        logic [31:0] v = '0;
        v[6:0] = 7'(id); v[10:8] = 3'(src); v[12] = cmd; v[27:20] = 8'(div); v[29] = en;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic measure(input int id, input int s, output int n);
        int guard = 0;
        n = 0;
        @(negedge clk);
        while (!gck_tick[id] && guard < 3000) begin @(negedge clk); guard++; end
        if (guard >= 3000) begin n = -1; return; end
        guard = 0;
        forever begin
            @(negedge clk); guard++;
            if (src_tick[s]) n++;
            if (gck_tick[id]) break;
            if (guard >= 3000) begin n = -1; break; end
        end
    endtask

    task automatic quiet(input int id, input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin @(negedge clk); if (gck_tick[id]) hits++; end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R8 rdata", reg_rdata, 32'h0);
        check("R8 ticks", gck_tick[31:0] | gck_tick[63:32], 32'h0);
    endtask

    task automatic t_select;
        wr(mk(7, 5, 99, 0, 1));
        check("R1 select-only", reg_rdata, mk(7, 0, 0, 0, 0));
    endtask

    task automatic t_load_and_period;
        int n;
        wr(mk(7, 2, 4, 1, 1));
        check("R2 load", reg_rdata, mk(7, 2, 4, 0, 1));
        measure(7, 2, n);
        check("R4 div4 period", 32'(n), 32'd5);
        wr(mk(12, 3, 2, 1, 1));
        check("R2 other entry", reg_rdata, mk(12, 3, 2, 0, 1));
        measure(12, 3, n);
        check("R4 div2 period", 32'(n), 32'd3);
    endtask

    task automatic t_bypass;
        int n, bad = 0;
        wr(mk(9, 1, 0, 1, 1));
        measure(9, 1, n);
        check("R4 div0 period", 32'(n), 32'd1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); if (gck_tick[9] !== src_tick[1]) bad++;
        end
        check("R4 passthrough", 32'(bad), 32'd0);
    endtask

    task automatic t_maxdiv;
        int n;
        wr(mk(63, 0, 255, 1, 1));
        measure(63, 0, n);
        check("R4 div255 period", 32'(n), 32'd256);
    endtask

    task automatic t_sources;
        int n, h;
        wr(mk(10, 6, 0, 1, 1));
        check("R5 src6 stored", reg_rdata, mk(10, 6, 0, 0, 1));
        quiet(10, 100, h);
        check("R5 src6 silent", 32'(h), 32'd0);
        wr(mk(11, 5, 1, 1, 1));
        measure(11, 5, n);
        check("R5 src5 period", 32'(n), 32'd2);
    endtask

    task automatic t_bad_id;
        int h;
        wr(mk(7, 0, 0, 0, 0));
        wr(mk(1, 1, 0, 1, 1));
        check("R6 id1 ignored", reg_rdata, mk(7, 2, 4, 0, 1));
        quiet(1, 40, h);
        check("R6 id1 silent", 32'(h), 32'd0);
        wr(mk(64, 1, 3, 1, 1));
        check("R6 id64 ignored", reg_rdata, mk(7, 2, 4, 0, 1));
        wr(mk(0, 0, 0, 0, 0));
        check("R6 id0 select ignored", reg_rdata, mk(7, 2, 4, 0, 1));
    endtask

    task automatic t_disable;
        int h;
        wr(mk(7, 5, 77, 1, 0));
        check("R3 disable keeps", reg_rdata, mk(7, 2, 4, 0, 0));
        @(negedge clk);
        quiet(7, 60, h);
        check("R3 output stops", 32'(h), 32'd0);
    endtask

    task automatic t_change_running;
        int n;
        wr(mk(5, 1, 3, 1, 1));
        measure(5, 1, n);
        check("R7 initial period", 32'(n), 32'd4);
        wr(mk(5, 1, 9, 1, 1));
        check("R7 readback new", reg_rdata, mk(5, 1, 9, 0, 1));
        measure(5, 1, n);
        check("R7 old period held", 32'(n), 32'd4);
        wr(mk(5, 0, 0, 1, 0));
        wr(mk(5, 1, 9, 1, 1));
        measure(5, 1, n);
        check("R7 new period after restart", 32'(n), 32'd10);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #150000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_select();
        t_load_and_period();
        t_bypass();
        t_maxdiv();
        t_sources();
        t_bad_id();
        t_disable();
        t_change_running();
        finish_run();
    end
endmodule